// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a 64-bit integer datapath that treats its two operands as a row of packed elements. A two-bit size input chooses the element width: 8, 16, 32 or 64 bits. A two-bit operation input chooses add, subtract or unsigned minimum. Every element of the row is computed in the same cycle.

A single 64-bit adder does all of the work. It is built from eight byte segments. The carry between two neighbouring segments is passed on only when both segments belong to the same element. At the first byte of each element the carry is replaced by the operation's carry-in. For subtract, the second operand is inverted and that carry-in is 1, so every lane computes A + ~B + 1 on its own. The minimum reuses that subtraction. Each lane inspects the carry out of its top byte and returns A when A is the smaller value, or B otherwise.

The result and an 8-bit per-lane carry vector are registered. They appear one clock after an accepted input, together with a one-cycle valid pulse. When no input is accepted, the registers keep their last values.

Top module: `simd_lane_alu`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid, out_result and out_cout are all zero.
- R2: The clock edge that samples in_valid high loads out_result and out_cout. out_valid is high for exactly the cycle after each cycle in which in_valid was high.
- R3: When in_valid is low at a clock edge, out_result and out_cout keep their previous values, whatever the operands, op_code or elem_sz do.
- R4: elem_sz selects the element width: 2'b00 for 8 bits, 2'b01 for 16, 2'b10 for 32 and 2'b11 for 64. Element i occupies bits [i*w +: w]. With op_code 2'b00, each element of out_result is (A+B) mod 2^w, and no carry crosses into the next element.
- R5: With op_code 2'b01, each element is (A-B) mod 2^w, computed as A + ~B + 1 with the 1 entered at the lowest bit of every element. No borrow crosses into the next element.
- R6: With op_code 2'b10, each element is the unsigned minimum: A when A < B, and B otherwise (B when the two are equal).
- R7: out_cout bit k belongs to byte k (bits [8k+7:8k]). It holds the carry out of bit 8k+7 of the lane adder when byte k is the top byte of an element, and 0 otherwise. For subtract and minimum the carry is that of A + ~B + 1, so 1 means A >= B.
- R8: op_code 2'b11 behaves exactly like add.
- R9: With elem_sz 2'b11, the 64 bits form a single lane: carries ripple through all eight bytes and only out_cout bit 7 can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present; result is registered on this edge |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| op_code | input | 2 | 00 add, 01 subtract, 10 unsigned min, 11 add |
| elem_sz | input | 2 | 00 byte, 01 halfword, 10 word, 11 doubleword |
| out_valid | output | 1 | One-cycle pulse, one clock after in_valid |
| out_result | output | 64 | Packed result |
| out_cout | output | 8 | Carry out at the top byte of each lane |

## Verification
The bench drives all-ones plus one at every element size. A design that leaks a carry across a lane boundary corrupts the next element and sets carry bits away from the lane tops. Subtracting one from zero in halfword lanes, and taking the minimum of 0x80 and 0x7F, expose a carry-in that is entered only at bit 0 and a comparison that is signed instead of unsigned. The hold case changes every input while in_valid is low, so registers that load on every clock show up at once. The reserved op code and the full-width carry ripple catch a decoder with a missing case and a chain that is still cut in 64-bit mode.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned SEG_W  = 8;
    localparam int unsigned NSEG   = DATA_W / SEG_W;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MIN = 2'b10,
        OP_RSV = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } elem_sz_e;

endpackage

// File: rtl/simd_lane_bounds.sv
// Decodes the element size into per-segment masks:
// lane_start marks the lowest segment of each lane, lane_top the highest.
module simd_lane_bounds
    import simd_alu_pkg::*;
#(
    parameter int unsigned NUM_SEG = NSEG
) (
    input  elem_sz_e             sz,
    output logic [NUM_SEG-1:0]   lane_start,
    output logic [NUM_SEG-1:0]   lane_top
);

    logic [31:0] span_mask;

    always_comb begin
        span_mask = (32'd1 << sz) - 32'd1;
        for (int k = 0; k < NUM_SEG; k++) begin
            lane_start[k] = ((32'(k) & span_mask) == 32'd0);
            lane_top[k]   = ((32'(k + 1) & span_mask) == 32'd0);
        end
    end

endmodule

// File: rtl/simd_seg_adder.sv
// Segmented adder: the carry between segments is cut at each lane start
// and replaced by the lane carry-in.
module simd_seg_adder #(
    parameter int unsigned SEG_WIDTH = 8,
    parameter int unsigned NUM_SEG   = 8,
    localparam int unsigned W        = SEG_WIDTH * NUM_SEG
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic               invert_b,
    input  logic [NUM_SEG-1:0] lane_start,
    output logic [W-1:0]       sum,
    output logic [NUM_SEG-1:0] seg_cout
);

    logic [W-1:0] b_eff;
    assign b_eff = invert_b ? ~b : b;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic               cin;
        logic               co;
        logic [SEG_WIDTH:0] part;

        if (g == 0) begin : g_first
            assign cin = invert_b;
        end else begin : g_rest
            assign cin = lane_start[g] ? invert_b : g_seg[g-1].co;
        end

        assign part = {1'b0, a[g*SEG_WIDTH +: SEG_WIDTH]}
                    + {1'b0, b_eff[g*SEG_WIDTH +: SEG_WIDTH]}
                    + {{SEG_WIDTH{1'b0}}, cin};
        assign co   = part[SEG_WIDTH];
        assign sum[g*SEG_WIDTH +: SEG_WIDTH] = part[SEG_WIDTH-1:0];
        assign seg_cout[g] = co;
    end

endmodule

// File: rtl/simd_lane_min.sv
// Per-lane unsigned minimum from the carry at each lane top of A + ~B + 1.
module simd_lane_min #(
    parameter int unsigned SEG_WIDTH = 8,
    parameter int unsigned NUM_SEG   = 8,
    localparam int unsigned W        = SEG_WIDTH * NUM_SEG
) (
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [NUM_SEG-1:0] seg_cout,
    input  logic [NUM_SEG-1:0] lane_top,
    output logic [W-1:0]       min_res
);

    logic a_less;

    always_comb begin
        a_less  = 1'b0;
        min_res = '0;
        for (int k = NUM_SEG - 1; k >= 0; k--) begin
            if (lane_top[k]) begin
                a_less = ~seg_cout[k];
            end
            min_res[k*SEG_WIDTH +: SEG_WIDTH] = a_less ? a[k*SEG_WIDTH +: SEG_WIDTH]
                                                       : b[k*SEG_WIDTH +: SEG_WIDTH];
        end
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int unsigned SEG_WIDTH = SEG_W,
    parameter int unsigned NUM_SEG   = NSEG,
    localparam int unsigned W        = SEG_WIDTH * NUM_SEG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    input  logic [1:0]         op_code,
    input  logic [1:0]         elem_sz,
    output logic               out_valid,
    output logic [W-1:0]       out_result,
    output logic [NUM_SEG-1:0] out_cout
);

    alu_op_e            op;
    elem_sz_e           sz;
    logic [NUM_SEG-1:0] lane_start;
    logic [NUM_SEG-1:0] lane_top;
    logic               invert_b;
    logic [W-1:0]       sum;
    logic [NUM_SEG-1:0] seg_cout;
    logic [W-1:0]       min_res;
    logic [W-1:0]       res_next;
    logic [NUM_SEG-1:0] cout_next;

    assign op = alu_op_e'(op_code);
    assign sz = elem_sz_e'(elem_sz);

    simd_lane_bounds #(.NUM_SEG(NUM_SEG)) u_bounds (
        .sz         (sz),
        .lane_start (lane_start),
        .lane_top   (lane_top)
    );

    always_comb begin
        unique case (op)
            OP_SUB, OP_MIN: invert_b = 1'b1;
            OP_ADD, OP_RSV: invert_b = 1'b0;
            default:        invert_b = 1'b0;
        endcase
    end

    simd_seg_adder #(.SEG_WIDTH(SEG_WIDTH), .NUM_SEG(NUM_SEG)) u_adder (
        .a          (op_a),
        .b          (op_b),
        .invert_b   (invert_b),
        .lane_start (lane_start),
        .sum        (sum),
        .seg_cout   (seg_cout)
    );

    simd_lane_min #(.SEG_WIDTH(SEG_WIDTH), .NUM_SEG(NUM_SEG)) u_min (
        .a        (op_a),
        .b        (op_b),
        .seg_cout (seg_cout),
        .lane_top (lane_top),
        .min_res  (min_res)
    );

    always_comb begin
        res_next  = (op == OP_MIN) ? min_res : sum;
        cout_next = seg_cout & lane_top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_cout   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res_next;
                out_cout   <= cout_next;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_cout)))
        else $error("result changed without in_valid"); // R3

    AST_COUT_AT_TOPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_cout & ~$past(lane_top)) == '0))
        else $error("carry bit set away from a lane top"); // R7

    AST_WIDE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_SUB && elem_sz == SZ_64)
        |=> out_result == W'($past(op_a) - $past(op_b)))
        else $error("full-width subtract wrong"); // R9

    AST_WIDE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MIN && elem_sz == SZ_64)
        |=> out_result == (($past(op_a) < $past(op_b)) ? $past(op_a) : $past(op_b)))
        else $error("full-width min wrong"); // R6

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_chk
        AST_BYTE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op_code == OP_ADD && elem_sz == SZ_8)
            |=> out_result[g*SEG_WIDTH +: SEG_WIDTH]
                == SEG_WIDTH'($past(op_a[g*SEG_WIDTH +: SEG_WIDTH])
                            + $past(op_b[g*SEG_WIDTH +: SEG_WIDTH])))
            else $error("byte lane add leaked a carry"); // R4
    end

endmodule

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  op_code = 2'b00;
    logic [1:0]  elem_sz = 2'b00;
    logic        out_valid;
    logic [63:0] out_result;
    logic [7:0]  out_cout;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    simd_lane_alu u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_code    (op_code),
        .elem_sz    (elem_sz),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_cout   (out_cout)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic void ref_calc(input logic [63:0] a, input logic [63:0] b,
                                     input logic [1:0] op, input logic [1:0] sz,
                                     output logic [63:0] r, output logic [7:0] c);
        int          w;
        logic [64:0] s;
        logic [63:0] m;
        logic [63:0] ea;
        logic [63:0] eb;
        logic [63:0] e;
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        c = '0;
        for (int l = 0; l < 64 / w; l++) begin
            ea = (a >> (l * w)) & m;
            eb = (b >> (l * w)) & m;
            if (op == 2'b01 || op == 2'b10)
                s = {1'b0, ea} + {1'b0, (~eb) & m} + 65'd1;
            else
                s = {1'b0, ea} + {1'b0, eb};
            if (op == 2'b10) e = s[w] ? eb : ea;
            else             e = s[63:0] & m;
            r = r | ((e & m) << (l * w));
            c[(l * w + w) / 8 - 1] = s[w];
        end
    endfunction

    // Applies one operation at a falling edge; checks the registered outputs
    // at the next falling edge.
    task automatic run_op(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] op, input logic [1:0] sz);
        logic [63:0] er;
        logic [7:0]  ec;
        ref_calc(a, b, op, sz, er, ec);
        op_a = a; op_b = b; op_code = op; elem_sz = sz; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check({tag, " result"}, out_result, er);
        check({tag, " R7 cout"}, {56'd0, out_cout}, {56'd0, ec});
        @(negedge clk);
        check({tag, " R2 pulse"}, {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", out_result, 64'd0);
        check("R1 cout", {56'd0, out_cout}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_add();
        for (int s = 0; s < 4; s++) begin
            run_op("R4 add ones", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 2'(s));
            run_op("R4 add mix", 64'h8899_AABB_CCDD_EEFF, 64'h7766_5544_3322_1101, 2'b00, 2'(s));
        end
        run_op("R4 byte explicit", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 2'b00);
        check("R4 byte lanes zero", out_result, 64'h0);
        check("R4 byte carries", {56'd0, out_cout}, 64'hFF);
    endtask

    task automatic t_sub();
        for (int s = 0; s < 4; s++) begin
            run_op("R5 sub", 64'h0000_1234_8000_00FF, 64'h0001_1235_7FFF_0100, 2'b01, 2'(s));
        end
        run_op("R5 half explicit", 64'h0, 64'h0001_0001_0001_0001, 2'b01, 2'b01);
        check("R5 half borrow lanes", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R5 half cout", {56'd0, out_cout}, 64'h0);
    endtask

    task automatic t_min();
        for (int s = 0; s < 4; s++) begin
            run_op("R6 min", 64'h8000_0001_7F00_FF80, 64'h7FFF_0001_8000_017F, 2'b10, 2'(s));
        end
        run_op("R6 unsigned byte", 64'h80, 64'h7F, 2'b10, 2'b00);
        check("R6 unsigned byte value", out_result[7:0], 64'h7F);
        run_op("R6 equal", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b10, 2'b10);
    endtask

    task automatic t_reserved();
        run_op("R8 reserved op", 64'hF0F0_1234_FFFF_0001, 64'h1010_EDCC_0001_FFFF, 2'b11, 2'b01);
    endtask

    task automatic t_wide();
        run_op("R9 ripple", 64'h00FF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 2'b11);
        check("R9 ripple value", out_result, 64'h0100_0000_0000_0000);
        run_op("R9 top carry", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'b00, 2'b11);
        check("R9 only bit7", {56'd0, out_cout}, 64'h80);
    endtask

    task automatic t_hold();
        logic [63:0] kept_r;
        logic [7:0]  kept_c;
        run_op("R3 setup", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 2'b00);
        kept_r = out_result;
        kept_c = out_cout;
        op_a = 64'h1111_2222_3333_4444; op_b = 64'h9999_8888_7777_6666;
        op_code = 2'b10; elem_sz = 2'b11;
        @(negedge clk);
        @(negedge clk);
        check("R3 result held", out_result, kept_r);
        check("R3 cout held", {56'd0, out_cout}, {56'd0, kept_c});
        check("R3 no valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_min();
        t_reserved();
        t_wide();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule